// File: doc/BRIEF.md
# Thermal Sensor Auto-Scan Controller

This block runs temperature-sensor conversions without software involvement. Once auto mode is enabled, it asks an external converter for a sample from each channel in turn (channel 0 first). It stores each returned code in a per-channel data register, and then waits a programmable number of timebase ticks before the next scan. If the latest stored sample of any channel is at or above that channel's compare value, the shorter high-temperature wait is used instead of the normal one. The stored value can be the raw code or 1024 minus the code.

Each channel counts consecutive samples at or above its compare value. Once that count reaches the interrupt debounce limit, the channel's pending bit is set, provided its interrupt is enabled. Once the count reaches the shutdown debounce limit, and the channel is enabled as a shutdown source, a sticky shutdown is raised on either the reset-controller pin or the power-IC GPIO pin, whichever is routed. Software programs the block through a plain read/write register port with byte addresses: control 0x04, enables 0x08, pending 0x0C, data 0x20+4·ch, compare 0x40+4·ch, interrupt debounce 0x60, shutdown debounce 0x64, normal wait 0x68, high-temperature wait 0x6C.

Top module: `thermal_scan_ctrl`

## Requirements
- R1: After reset, irq_o, adc_req_o and the internal shutdown state are inactive. Both shutdown pins are high because the polarity defaults to active low. The normal wait reads 250, the high-temperature wait 50, and both debounce limits read 4.
- R2: Setting control bit 0 (auto) starts a scan at once. Each scan converts channel 0, then 1, up to the last, and adc_chan_o holds the channel number for the whole request.
- R3: adc_req_o stays high until adc_done_i is sampled high. The adc_data_i of that cycle is stored in the data register of that channel.
- R4: When control bit 1 is set, the stored value is (1024 − code) truncated to DATA_W bits. When the bit is clear, the code is stored as is.
- R5: From the clock edge that captures the last channel to the edge that raises the next request, exactly P·CYC_PER_TICK cycles pass. P is the normal wait, or the high-temperature wait when any channel's stored sample is ≥ its compare value.
- R6: A channel's pending bit (bit ch at 0x0C) sets once it has seen N consecutive samples ≥ its compare value, where N is the interrupt debounce limit, and only if enable bit ch at 0x08 is set. A sample below the compare value restarts the count. irq_o is the OR of the pending bits.
- R7: Writing 1 to pending bit ch clears it. Pending bit STATUS_BIT (default 16) reads 1 once any shutdown has occurred, and writes leave it unchanged.
- R8: After M consecutive samples ≥ the compare value, where M is the shutdown debounce limit, a channel with control bit 4+ch set raises the shutdown. It goes to the GPIO pin when enable bit 4+ch is set, and to the reset-controller pin when enable bit 8+ch is set. The shutdown stays raised until reset.
- R9: Control bit 8 selects the shutdown level: 1 drives an active shutdown pin high, 0 drives it low.
- R10: Clearing auto lets a conversion already requested complete and be stored. After that no request is made, and the data registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register byte address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| adc_req_o | output | 1 | Conversion request |
| adc_chan_o | output | CH_W | Channel being converted |
| adc_done_i | input | 1 | Conversion finished, data valid |
| adc_data_i | input | DATA_W | Raw conversion code |
| irq_o | output | 1 | Interrupt, OR of pending bits |
| shut_gpio_o | output | 1 | Shutdown toward the power IC |
| shut_rstc_o | output | 1 | Shutdown toward the reset controller |

## Verification
The hardest state to reach is a request already in flight at the moment auto mode is switched off. The stimulus waits at a falling edge until it sees a request, records the channel, and then writes the control register within the converter model's two-cycle latency, so the done pulse arrives after auto is already off. The second hard case is a debounce count interrupted by a cool sample. The bench changes the modelled converter's code between scans, timed by completed scans counted in the converter model, so the exact pattern over, over, under, over, over, over is applied.

// File: rtl/thermal_scan_pkg.sv
package thermal_scan_pkg;
  localparam int unsigned OFS_CTRL  = 'h04;
  localparam int unsigned OFS_EN    = 'h08;
  localparam int unsigned OFS_PEND  = 'h0C;
  localparam int unsigned OFS_DATA  = 'h20;
  localparam int unsigned OFS_CMP   = 'h40;
  localparam int unsigned OFS_IDEB  = 'h60;
  localparam int unsigned OFS_SDEB  = 'h64;
  localparam int unsigned OFS_PER   = 'h68;
  localparam int unsigned OFS_PERHT = 'h6C;

  localparam int BIT_AUTO = 0;
  localparam int BIT_INV  = 1;
  localparam int BIT_SRC  = 4;
  localparam int BIT_POL  = 8;
  localparam int BIT_IRQ  = 0;
  localparam int BIT_GPIO = 4;
  localparam int BIT_RSTC = 8;

  localparam int INV_BASE = 1024;

  typedef enum logic [1:0] {ST_IDLE, ST_CONV, ST_WAIT} scan_state_e;
endpackage

// File: rtl/scan_tick.sv
module scan_tick #(
  parameter int unsigned CYC_PER_TICK = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned PW = (CYC_PER_TICK > 1) ? $clog2(CYC_PER_TICK) : 1;

  logic [PW-1:0] pre_q;

  assign tick_o = run_i && (pre_q == PW'(CYC_PER_TICK - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pre_q <= '0;
    else if (!run_i || tick_o)  pre_q <= '0;
    else                        pre_q <= pre_q + PW'(1);
  end
endmodule

// File: rtl/scan_seq.sv
module scan_seq
  import thermal_scan_pkg::*;
#(
  parameter int unsigned NCH   = 2,
  parameter int unsigned PER_W = 16,
  parameter int unsigned CH_W  = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             auto_en_i,
  input  logic             tick_i,
  input  logic [PER_W-1:0] period_i,
  input  logic             adc_done_i,
  output logic             req_o,
  output logic [CH_W-1:0]  chan_o,
  output logic             cap_o,
  output logic             wait_o
);
  scan_state_e      state_q;
  logic [CH_W-1:0]  chan_q;
  logic [PER_W-1:0] pcnt_q;
  logic [PER_W:0]   pnext;
  logic             expire;

  assign req_o  = (state_q == ST_CONV);
  assign wait_o = (state_q == ST_WAIT);
  assign cap_o  = req_o && adc_done_i;
  assign chan_o = chan_q;
  assign pnext  = {1'b0, pcnt_q} + (PER_W+1)'(1);
  // a zero wait behaves like one tick
  assign expire = tick_i && (pnext >= {1'b0, period_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      chan_q  <= '0;
      pcnt_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (auto_en_i) begin
          state_q <= ST_CONV;
          chan_q  <= '0;
        end
        ST_CONV: if (adc_done_i) begin
          if (!auto_en_i) begin
            state_q <= ST_IDLE;
            chan_q  <= '0;
          end else if (chan_q == CH_W'(NCH - 1)) begin
            state_q <= ST_WAIT;
            chan_q  <= '0;
            pcnt_q  <= '0;
          end else begin
            chan_q  <= chan_q + CH_W'(1);
          end
        end
        ST_WAIT: begin
          if (!auto_en_i)   state_q <= ST_IDLE;
          else if (expire)  state_q <= ST_CONV;
          else if (tick_i)  pcnt_q  <= pnext[PER_W-1:0];
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_req_held_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !adc_done_i |=> req_o);
  assert_chan_stable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !adc_done_i |=> $stable(chan_o));
  assert_start_needs_auto_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) |-> $past(auto_en_i));
endmodule

// File: rtl/chan_mon.sv
module chan_mon #(
  parameter int unsigned DATA_W = 10,
  parameter int unsigned DEB_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [DATA_W-1:0] sample_i,
  input  logic [DATA_W-1:0] cmp_i,
  input  logic [DEB_W-1:0]  int_deb_i,
  input  logic [DEB_W-1:0]  shut_deb_i,
  output logic [DATA_W-1:0] data_o,
  output logic              hot_o,
  output logic              int_hit_o,
  output logic              shut_hit_o
);
  logic [DATA_W-1:0] data_q;
  logic [DEB_W-1:0]  cnt_q, cnt_nxt;
  logic              over_new;

  assign over_new = (sample_i >= cmp_i);
  always_comb begin
    if (!over_new)              cnt_nxt = '0;
    else if (cnt_q == '1)       cnt_nxt = cnt_q;
    else                        cnt_nxt = cnt_q + DEB_W'(1);
  end

  // one saturating run length serves both limits
  assign int_hit_o  = cap_i && over_new && (cnt_nxt >= int_deb_i);
  assign shut_hit_o = cap_i && over_new && (cnt_nxt >= shut_deb_i);
  assign hot_o      = (data_q >= cmp_i);
  assign data_o     = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      cnt_q  <= '0;
    end else if (cap_i) begin
      data_q <= sample_i;
      cnt_q  <= cnt_nxt;
    end
  end

  assert_data_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(data_o));
endmodule

// File: rtl/thermal_scan_ctrl.sv
module thermal_scan_ctrl
  import thermal_scan_pkg::*;
#(
  parameter int unsigned NCH          = 2,
  parameter int unsigned DATA_W       = 10,
  parameter int unsigned DEB_W        = 8,
  parameter int unsigned PER_W        = 16,
  parameter int unsigned ADDR_W       = 8,
  parameter int unsigned CYC_PER_TICK = 1000,
  parameter int unsigned STATUS_BIT   = 16,
  localparam int unsigned CH_W        = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              adc_req_o,
  output logic [CH_W-1:0]   adc_chan_o,
  input  logic              adc_done_i,
  input  logic [DATA_W-1:0] adc_data_i,
  output logic              irq_o,
  output logic              shut_gpio_o,
  output logic              shut_rstc_o
);
  logic auto_q, inv_q, pol_q;
  logic [NCH-1:0] src_q, irq_en_q, gpio_rt_q, rstc_rt_q, pend_q;
  logic [NCH-1:0][DATA_W-1:0] cmp_q, data_w;
  logic [DEB_W-1:0] ideb_q, sdeb_q;
  logic [PER_W-1:0] per_q, perht_q, per_sel;
  logic shut_gpio_q, shut_rstc_q;
  logic [NCH-1:0] hot_w, int_hit, shut_hit;
  logic tick, cap, wait_st;
  logic [DATA_W-1:0] sample;
  logic unused_wdata;

  assign unused_wdata = ^reg_wdata_i;

  function automatic logic hit(input int unsigned ofs);
    return reg_addr_i == ADDR_W'(ofs);
  endfunction

  assign sample  = inv_q ? DATA_W'(INV_BASE - int'(adc_data_i)) : adc_data_i;
  assign per_sel = (|hot_w) ? perht_q : per_q;

  scan_tick #(.CYC_PER_TICK(CYC_PER_TICK)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(wait_st), .tick_o(tick));

  scan_seq #(.NCH(NCH), .PER_W(PER_W), .CH_W(CH_W)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .auto_en_i(auto_q), .tick_i(tick),
    .period_i(per_sel), .adc_done_i(adc_done_i), .req_o(adc_req_o),
    .chan_o(adc_chan_o), .cap_o(cap), .wait_o(wait_st));

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    chan_mon #(.DATA_W(DATA_W), .DEB_W(DEB_W)) u_mon (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .cap_i(cap && (adc_chan_o == CH_W'(g))),
      .sample_i(sample), .cmp_i(cmp_q[g]),
      .int_deb_i(ideb_q), .shut_deb_i(sdeb_q),
      .data_o(data_w[g]), .hot_o(hot_w[g]),
      .int_hit_o(int_hit[g]), .shut_hit_o(shut_hit[g]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      auto_q <= 1'b0; inv_q <= 1'b0; pol_q <= 1'b0; src_q <= '0;
      irq_en_q <= '0; gpio_rt_q <= '0; rstc_rt_q <= '0;
      cmp_q <= '1;
      ideb_q <= DEB_W'(4); sdeb_q <= DEB_W'(4);
      per_q <= PER_W'(250); perht_q <= PER_W'(50);
    end else if (reg_we_i) begin
      if (hit(OFS_CTRL)) begin
        auto_q <= reg_wdata_i[BIT_AUTO];
        inv_q  <= reg_wdata_i[BIT_INV];
        pol_q  <= reg_wdata_i[BIT_POL];
        src_q  <= reg_wdata_i[BIT_SRC +: NCH];
      end
      if (hit(OFS_EN)) begin
        irq_en_q  <= reg_wdata_i[BIT_IRQ +: NCH];
        gpio_rt_q <= reg_wdata_i[BIT_GPIO +: NCH];
        rstc_rt_q <= reg_wdata_i[BIT_RSTC +: NCH];
      end
      for (int i = 0; i < NCH; i++)
        if (hit(OFS_CMP + 4*i)) cmp_q[i] <= reg_wdata_i[DATA_W-1:0];
      if (hit(OFS_IDEB))  ideb_q  <= reg_wdata_i[DEB_W-1:0];
      if (hit(OFS_SDEB))  sdeb_q  <= reg_wdata_i[DEB_W-1:0];
      if (hit(OFS_PER))   per_q   <= reg_wdata_i[PER_W-1:0];
      if (hit(OFS_PERHT)) perht_q <= reg_wdata_i[PER_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      shut_gpio_q <= 1'b0;
      shut_rstc_q <= 1'b0;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (int_hit[i] && irq_en_q[i])
          pend_q[i] <= 1'b1;
        else if (reg_we_i && hit(OFS_PEND) && reg_wdata_i[BIT_IRQ + i])
          pend_q[i] <= 1'b0;
      end
      shut_gpio_q <= shut_gpio_q | (|(shut_hit & src_q & gpio_rt_q));
      shut_rstc_q <= shut_rstc_q | (|(shut_hit & src_q & rstc_rt_q));
    end
  end

  assign irq_o       = |pend_q;
  assign shut_gpio_o = pol_q ? shut_gpio_q : ~shut_gpio_q;
  assign shut_rstc_o = pol_q ? shut_rstc_q : ~shut_rstc_q;

  always_comb begin
    reg_rdata_o = '0;
    if (hit(OFS_CTRL)) begin
      reg_rdata_o[BIT_AUTO] = auto_q;
      reg_rdata_o[BIT_INV]  = inv_q;
      reg_rdata_o[BIT_POL]  = pol_q;
      reg_rdata_o[BIT_SRC +: NCH] = src_q;
    end
    if (hit(OFS_EN)) begin
      reg_rdata_o[BIT_IRQ +: NCH]  = irq_en_q;
      reg_rdata_o[BIT_GPIO +: NCH] = gpio_rt_q;
      reg_rdata_o[BIT_RSTC +: NCH] = rstc_rt_q;
    end
    if (hit(OFS_PEND)) begin
      reg_rdata_o[BIT_IRQ +: NCH] = pend_q;
      reg_rdata_o[STATUS_BIT]     = shut_gpio_q | shut_rstc_q;
    end
    for (int i = 0; i < NCH; i++) begin
      if (hit(OFS_DATA + 4*i)) reg_rdata_o[DATA_W-1:0] = data_w[i];
      if (hit(OFS_CMP + 4*i))  reg_rdata_o[DATA_W-1:0] = cmp_q[i];
    end
    if (hit(OFS_IDEB))  reg_rdata_o[DEB_W-1:0] = ideb_q;
    if (hit(OFS_SDEB))  reg_rdata_o[DEB_W-1:0] = sdeb_q;
    if (hit(OFS_PER))   reg_rdata_o[PER_W-1:0] = per_q;
    if (hit(OFS_PERHT)) reg_rdata_o[PER_W-1:0] = perht_q;
  end

  assert_irq_at_capture_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(cap));
  assert_gpio_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shut_gpio_q |=> shut_gpio_q);
  assert_rstc_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shut_rstc_q |=> shut_rstc_q);
  assert_no_shut_rise_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(shut_gpio_q) || $rose(shut_rstc_q)) |-> $past(cap));
endmodule

// File: tb/tb_thermal_scan_ctrl.sv
module tb_thermal_scan_ctrl;
  localparam int CPT = 2;
  localparam int LAT = 2;
  localparam int A_CTRL = 'h04, A_EN = 'h08, A_PEND = 'h0C, A_D0 = 'h20, A_D1 = 'h24;
  localparam int A_C0 = 'h40, A_C1 = 'h44, A_IDEB = 'h60, A_SDEB = 'h64;
  localparam int A_PER = 'h68, A_PERHT = 'h6C;

  // {inv, raw0, raw1, exp0, exp1}
  localparam logic [43:0] VEC [6] = '{
    {4'd0, 10'd100,  10'd900, 10'd100,  10'd900},
    {4'd0, 10'd0,    10'd1023,10'd0,    10'd1023},
    {4'd1, 10'd100,  10'd900, 10'd924,  10'd124},
    {4'd1, 10'd0,    10'd512, 10'd0,    10'd512},
    {4'd1, 10'd1023, 10'd1,   10'd1,    10'd1023},
    {4'd0, 10'd345,  10'd678, 10'd345,  10'd678}
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic reg_we = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic adc_req_o, adc_done = 1'b0, irq_o, shut_gpio_o, shut_rstc_o;
  logic [0:0] adc_chan_o;
  logic [9:0] adc_data = '0;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int adc_val [2] = '{0, 0};
  int scan_cnt = 0, conv_cnt = 0, gap_seq = 0, last_gap = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  thermal_scan_ctrl #(.CYC_PER_TICK(CPT)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .adc_req_o(adc_req_o),
    .adc_chan_o(adc_chan_o), .adc_done_i(adc_done), .adc_data_i(adc_data),
    .irq_o(irq_o), .shut_gpio_o(shut_gpio_o), .shut_rstc_o(shut_rstc_o));

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); reg_we = 1'b1; reg_addr = 8'(a); reg_wdata = 32'(d);
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk); reg_addr = 8'(a); #1 v = int'(reg_rdata);
  endtask

  task automatic wait_scans(input int n);
    int target;
    target = scan_cnt + n;
    wait (scan_cnt >= target);
  endtask

  task automatic do_reset();
    wr(A_CTRL, 0);
    repeat (40) @(negedge clk);
    rst_ni = 1'b0; adc_val[0] = 0; adc_val[1] = 0;
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  // converter model: fixed latency, checks round-robin order, measures waits
  initial begin
    int exp_ch, ch, done_edge;
    bit gap_pend;
    exp_ch = 0; gap_pend = 0; done_edge = 0;
    forever begin
      @(negedge clk);
      if (!rst_ni) begin
        exp_ch = 0; gap_pend = 0;
      end else if (adc_req_o) begin
        if (gap_pend) begin
          last_gap = cyc - done_edge; gap_seq++; gap_pend = 0;
        end
        ch = int'(adc_chan_o);
        chk("R2 channel order", ch, exp_ch);
        repeat (LAT) @(negedge clk);
        adc_data = 10'(adc_val[ch]); adc_done = 1'b1;
        @(negedge clk);
        adc_done = 1'b0; conv_cnt++;
        exp_ch = (ch == 1) ? 0 : ch + 1;
        if (ch == 1) begin
          done_edge = cyc; gap_pend = 1; scan_cnt++;
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int v, g, ch, e0, e1, c;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", int'(irq_o), 0);
    chk("R1 req", int'(adc_req_o), 0);
    chk("R1 gpio pin", int'(shut_gpio_o), 1);
    chk("R1 rstc pin", int'(shut_rstc_o), 1);
    rd(A_PER, v);   chk("R1 period", v, 250);
    rd(A_PERHT, v); chk("R1 hot period", v, 50);
    rd(A_IDEB, v);  chk("R1 int debounce", v, 4);
    rd(A_SDEB, v);  chk("R1 shut debounce", v, 4);
    rd(A_PEND, v);  chk("R1 pending", v, 0);

    // vector table: capture and inversion, R3 R4
    wr(A_PER, 4); wr(A_PERHT, 2);
    for (int i = 0; i < 6; i++) begin
      adc_val[0] = int'(VEC[i][39:30]);
      adc_val[1] = int'(VEC[i][29:20]);
      wr(A_CTRL, 1 | (int'(VEC[i][40]) << 1));
      wait_scans(2);
      rd(A_D0, v); chk("R3 R4 data0", v, int'(VEC[i][19:10]));
      rd(A_D1, v); chk("R3 R4 data1", v, int'(VEC[i][9:0]));
    end

    // R5 normal wait then high-temperature wait
    g = gap_seq; wait (gap_seq > g);
    chk("R5 normal wait", last_gap, 4 * CPT);
    wr(A_C0, 50);
    wait_scans(1);
    g = gap_seq; wait (gap_seq > g);
    chk("R5 hot wait", last_gap, 2 * CPT);

    // R6 debounce to interrupt, R7 clear
    do_reset();
    wr(A_PER, 8); wr(A_PERHT, 8); wr(A_C0, 500); wr(A_IDEB, 3); wr(A_EN, 1);
    adc_val[0] = 600;
    wr(A_CTRL, 1);
    wait_scans(1); chk("R6 no irq after 1", int'(irq_o), 0);
    wait_scans(1); chk("R6 no irq after 2", int'(irq_o), 0);
    wait_scans(1); chk("R6 irq after 3", int'(irq_o), 1);
    wr(A_PEND, 1);
    rd(A_PEND, v); chk("R7 pending cleared", v, 0);
    chk("R7 irq cleared", int'(irq_o), 0);

    // R6 cool sample restarts count
    do_reset();
    wr(A_PER, 8); wr(A_PERHT, 8); wr(A_C0, 500); wr(A_IDEB, 3); wr(A_EN, 1);
    adc_val[0] = 600;
    wr(A_CTRL, 1);
    wait_scans(1); adc_val[0] = 600;
    wait_scans(1); adc_val[0] = 400;
    wait_scans(1); adc_val[0] = 600;
    wait_scans(1);
    wait_scans(1); chk("R6 restart no irq", int'(irq_o), 0);
    wait_scans(1); chk("R6 restart irq", int'(irq_o), 1);

    // R8 R9 R7: reset-controller route, active high, sticky
    do_reset();
    wr(A_PER, 4); wr(A_PERHT, 4); wr(A_C1, 300); wr(A_SDEB, 2); wr(A_EN, 1 << 9);
    adc_val[1] = 400;
    wr(A_CTRL, 1 | (1 << 5) | (1 << 8));
    chk("R9 rstc inactive high pol", int'(shut_rstc_o), 0);
    wait_scans(1); chk("R8 no shut after 1", int'(shut_rstc_o), 0);
    wait_scans(1); chk("R8 rstc shut", int'(shut_rstc_o), 1);
    chk("R8 gpio not routed", int'(shut_gpio_o), 0);
    rd(A_PEND, v); chk("R7 status bit", (v >> 16) & 1, 1);
    wr(A_PEND, -1);
    rd(A_PEND, v); chk("R7 status kept", (v >> 16) & 1, 1);
    adc_val[1] = 100;
    wait_scans(2);
    chk("R8 sticky", int'(shut_rstc_o), 1);
    chk("R6 irq gated", int'(irq_o), 0);

    // R8 R9: GPIO route, active low
    do_reset();
    wr(A_PER, 4); wr(A_C0, 10); wr(A_SDEB, 1); wr(A_EN, 1 << 4);
    adc_val[0] = 20;
    wr(A_CTRL, 1 | (1 << 4));
    wait_scans(1);
    chk("R9 gpio active low", int'(shut_gpio_o), 0);
    chk("R8 rstc untouched", int'(shut_rstc_o), 1);

    // R10 disable with a conversion in flight
    do_reset();
    wr(A_PER, 4); wr(A_PERHT, 4);
    adc_val[0] = 111; adc_val[1] = 222;
    wr(A_CTRL, 1);
    wait_scans(1);
    do @(negedge clk); while (!adc_req_o);
    ch = int'(adc_chan_o);
    adc_val[0] = 333; adc_val[1] = 444;
    wr(A_CTRL, 0);
    repeat (10) @(negedge clk);
    c = conv_cnt;
    repeat (60) @(negedge clk);
    chk("R10 no new requests", conv_cnt, c);
    chk("R10 req low", int'(adc_req_o), 0);
    e0 = (ch == 0) ? 333 : 111;
    e1 = (ch == 1) ? 444 : 222;
    rd(A_D0, v); chk("R10 data0 in flight", v, e0);
    rd(A_D1, v); chk("R10 data1 in flight", v, e1);
    adc_val[0] = 555; adc_val[1] = 555;
    repeat (60) @(negedge clk);
    rd(A_D0, v); chk("R10 data0 kept", v, e0);
    rd(A_D1, v); chk("R10 data1 kept", v, e1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule